// File: doc/BRIEF.md
# Operand Hazard Unit

This block decides, for the instruction sitting in decode of a five-stage in-order integer pipeline, where each of its two source operands must come from when it reaches execute. It keeps a small control shadow of the execute, memory and writeback stages: validity, write enable, load flag, a store-bypass flag and the destination register number. Against that shadow it checks the decode sources every cycle.

The outputs give, per operand, a forwarding select and a read-after-write flag. They also give a hold for the fetch and decode stages and a bubble request for execute when a load result is needed too early. A separate flag tells the memory stage to take store data from the load ahead of it. The register file is assumed to write early and read late in a cycle, so a producer in writeback needs no bypass. The selects are valid in decode and are meant to be registered alongside the operands into the execute stage.

Top module: `operand_hazard_unit`

## Requirements
- R1: A source operand of a valid decode instruction is flagged as a read-after-write hazard when it equals the destination of an execute, memory or writeback stage entry whose write enable is set.
- R2: Register number 0 never produces a hazard flag or a forward, even when a stage holds destination 0 with write enable set.
- R3: Each operand select uses 2'b00 for the register file, 2'b01 for the result of the instruction now in execute (taken from the execute/memory register next cycle) and 2'b10 for the instruction now in memory (taken from the memory/writeback register next cycle); a match only in writeback gives 2'b00.
- R4: When execute and memory both write the operand's register, the select names the execute-stage (youngest) producer.
- R5: When a load in execute writes a register read by the decode instruction, the fetch/decode hold and the execute bubble are both asserted in that cycle, and the operand select is 2'b00.
- R6: The entry written into execute on a bubble has valid and write enable cleared and keeps the decode destination number, and it never matches a later source.
- R7: A store whose data source (second operand) matches a load in execute, and whose address source does not, causes no hold; the memory-stage store bypass output is high exactly in the cycle that store occupies the memory stage.
- R8: Hold depends only on a load in execute; a load in the memory stage is served by select 2'b10 without a hold.
- R9: An invalid decode slot raises no hazard flag and no hold, and its selects are 2'b00.
- R10: Synchronous active-low reset empties all three stage entries: execute not valid, no store bypass, execute destination 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs | input | REG_AW | First source register number |
| id_rt | input | REG_AW | Second source (store data) register number |
| id_rd | input | REG_AW | Destination register number |
| id_we | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_store | input | 1 | Decode instruction is a store |
| fwd_rs_sel | output | 2 | Forward select for the first operand |
| fwd_rt_sel | output | 2 | Forward select for the second operand |
| raw_rs | output | 1 | First operand has a pending producer |
| raw_rt | output | 1 | Second operand has a pending producer |
| hold_front | output | 1 | Freeze fetch and decode this cycle |
| ex_bubble | output | 1 | Insert an empty entry into execute |
| ex_valid | output | 1 | Execute entry is a real instruction |
| ex_we | output | 1 | Execute entry writes a register |
| ex_rd | output | REG_AW | Execute entry destination number |
| mem_store_bypass | output | 1 | Store in memory takes its data from the load in writeback |

## Verification
The bench builds the block with the package default of 5-bit register numbers, so the full range from register 0 to register 31 is reachable. That brings in the zero-register exclusion and the top register used as a doubly written destination. With this width, a hand-written instruction stream can place a load, a dependent store and a competing older producer in execute, memory and writeback at once. The stream also covers a stall released into a memory-stage forward, a store whose address and data both depend on a load, and a reset issued while a load is in decode.

// File: rtl/ohu_pkg.sv
// Shared types for the operand hazard unit.
// Assumes: a five-stage in-order pipeline with a register file that writes in
// the first half of a cycle and reads in the second half.
package ohu_pkg;
    parameter int REG_AW = 5;          // register number width
    localparam int NUM_SRC = 2;        // source operands per instruction
    localparam int NUM_STG = 3;        // tracked stages after decode
    localparam int S_EX  = 0;
    localparam int S_MEM = 1;
    localparam int S_WB  = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_EXMEM = 2'b01,
        FWD_MEMWB = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     valid;
        logic     we;
        logic     ld;
        logic     st_byp;
        reg_idx_t rd;
    } stage_ctl_t;
endpackage

// File: rtl/ohu_stage_pipe.sv
// Control shadow of the execute, memory and writeback stages.
// Entry 0 takes the decode control word, or an emptied copy of it when a
// bubble is requested; later entries shift one stage per clock.
// Assumes: the pipeline never stalls below decode.
module ohu_stage_pipe
    import ohu_pkg::*;
#(
    parameter int DEPTH = NUM_STG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  stage_ctl_t id_ctl,
    input  logic       bubble,
    output stage_ctl_t st_q [DEPTH]
);
    stage_ctl_t entry_nxt;

    // Build the word entering execute; a bubble keeps only the register number.
    always_comb begin
        entry_nxt = id_ctl;
        if (bubble) begin
            entry_nxt.valid  = 1'b0;
            entry_nxt.we     = 1'b0;
            entry_nxt.ld     = 1'b0;
            entry_nxt.st_byp = 1'b0;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Capture the new execute entry.
            always_ff @(posedge clk) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= entry_nxt;
            end
        end else begin : g_tail
            // Advance the entry from the stage above.
            always_ff @(posedge clk) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_q[g-1];
            end
        end
    end

    // R6: a bubble leaves an empty execute entry
    a_r6_bubble_empty: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!st_q[0].valid && !st_q[0].we && !st_q[0].ld));

    // R6: a bubble keeps the decode destination number
    a_r6_bubble_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (st_q[0].rd == $past(id_ctl.rd)));
endmodule

// File: rtl/ohu_src_match.sv
// Compares one decode source against the three tracked stages and picks the
// forwarding select from the nearest producer.
// Assumes: a select is consumed one cycle later, after every producer has
// advanced by one stage; writeback producers are read from the register file.
module ohu_src_match
    import ohu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_valid,
    input  reg_idx_t   src,
    input  stage_ctl_t ex_e,
    input  stage_ctl_t mem_e,
    input  stage_ctl_t wb_e,
    output logic       raw,
    output logic       ld_hit,
    output fwd_sel_e   sel
);
    logic src_live;
    logic hit_ex, hit_mem, hit_wb;

    // Per-stage comparison; register 0 is never a dependency.
    always_comb begin
        src_live = id_valid && (src != '0);
        hit_ex   = src_live && ex_e.valid  && ex_e.we  && (ex_e.rd  == src);
        hit_mem  = src_live && mem_e.valid && mem_e.we && (mem_e.rd == src);
        hit_wb   = src_live && wb_e.valid  && wb_e.we  && (wb_e.rd  == src);
    end

    // Hazard flag and load-in-execute hit.
    always_comb begin
        raw    = hit_ex || hit_mem || hit_wb;
        ld_hit = hit_ex && ex_e.ld;
    end

    // Nearest-producer select; a load in execute cannot be forwarded yet.
    always_comb begin
        if (hit_ex)       sel = ex_e.ld ? FWD_RF : FWD_EXMEM;
        else if (hit_mem) sel = FWD_MEMWB;
        else              sel = FWD_RF;
    end

    // R2: register 0 stays quiet
    a_r2_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (!raw && sel == FWD_RF));

    // R3: only the three defined codes appear
    a_r3_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sel != fwd_sel_e'(2'b11));

    // R4: the memory path is never chosen over a forwardable execute producer
    a_r4_nearest: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_MEMWB) |-> !(ex_e.valid && ex_e.we && !ex_e.ld && ex_e.rd == src));

    // R9: an empty decode slot selects the register file
    a_r9_idle_rf: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (sel == FWD_RF && !raw && !ld_hit));
endmodule

// File: rtl/ohu_loaduse.sv
// Turns load-in-execute hits into a front-end hold or a store-data bypass.
// Assumes: the second operand of a store is its data, the first its address.
module ohu_loaduse (
    input  logic clk,
    input  logic rst_n,
    input  logic id_store,
    input  logic ld_hit_rs,
    input  logic ld_hit_rt,
    output logic stall,
    output logic st_byp
);
    // Store data from the load ahead is patched in memory; anything else waits.
    always_comb begin
        st_byp = id_store && ld_hit_rt && !ld_hit_rs;
        stall  = ld_hit_rs || (ld_hit_rt && !id_store);
    end

    // R7: the store bypass replaces the stall, never joins it
    a_r7_byp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        st_byp |-> !stall);

    // R5: no stall without a load hit
    a_r5_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ld_hit_rs || ld_hit_rt));
endmodule

// File: rtl/operand_hazard_unit.sv
// Operand hazard control for a five-stage in-order pipeline: forwarding
// selects, read-after-write flags, load-use hold/bubble and a memory-stage
// store-data bypass flag.
// Assumes: decode inputs are held by the front end while hold_front is high.
module operand_hazard_unit
    import ohu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_we,
    input  logic              id_load,
    input  logic              id_store,
    output logic [1:0]        fwd_rs_sel,
    output logic [1:0]        fwd_rt_sel,
    output logic              raw_rs,
    output logic              raw_rt,
    output logic              hold_front,
    output logic              ex_bubble,
    output logic              ex_valid,
    output logic              ex_we,
    output logic [REG_AW-1:0] ex_rd,
    output logic              mem_store_bypass
);
    stage_ctl_t stg [NUM_STG];
    stage_ctl_t id_ctl;
    reg_idx_t   src_idx [NUM_SRC];
    logic       raw_v   [NUM_SRC];
    logic       ldhit_v [NUM_SRC];
    fwd_sel_e   sel_v   [NUM_SRC];
    logic       stall;
    logic       st_byp;

    // Collect the source numbers in operand order.
    always_comb begin
        src_idx[0] = id_rs;
        src_idx[1] = id_rt;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        ohu_src_match u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .id_valid (id_valid),
            .src      (src_idx[s]),
            .ex_e     (stg[S_EX]),
            .mem_e    (stg[S_MEM]),
            .wb_e     (stg[S_WB]),
            .raw      (raw_v[s]),
            .ld_hit   (ldhit_v[s]),
            .sel      (sel_v[s])
        );
    end

    ohu_loaduse u_loaduse (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_store  (id_store && id_valid),
        .ld_hit_rs (ldhit_v[0]),
        .ld_hit_rt (ldhit_v[1]),
        .stall     (stall),
        .st_byp    (st_byp)
    );

    // Control word that decode hands to execute.
    always_comb begin
        id_ctl.valid  = id_valid;
        id_ctl.we     = id_valid && id_we;
        id_ctl.ld     = id_valid && id_load;
        id_ctl.st_byp = st_byp;
        id_ctl.rd     = id_rd;
    end

    ohu_stage_pipe #(.DEPTH(NUM_STG)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .id_ctl (id_ctl),
        .bubble (stall),
        .st_q   (stg)
    );

    // Drive the block outputs.
    always_comb begin
        fwd_rs_sel       = sel_v[0];
        fwd_rt_sel       = sel_v[1];
        raw_rs           = raw_v[0];
        raw_rt           = raw_v[1];
        hold_front       = stall;
        ex_bubble        = stall;
        ex_valid         = stg[S_EX].valid;
        ex_we            = stg[S_EX].we;
        ex_rd            = stg[S_EX].rd;
        mem_store_bypass = stg[S_MEM].st_byp;
    end

    // R5: a hold is only ever caused by a load sitting in execute
    a_r5_hold_needs_ex_load: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front |-> (stg[S_EX].valid && stg[S_EX].ld));

    // R8: a load in memory with no load in execute never holds the front end
    a_r8_mem_load_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stg[S_MEM].ld && !stg[S_EX].ld) |-> !hold_front);

    // R7: the memory bypass flag belongs to a store decoded two cycles earlier
    a_r7_mem_byp_origin: assert property (@(posedge clk) disable iff (!rst_n)
        mem_store_bypass |-> $past(st_byp, 2));

    // R10: reset leaves the execute entry empty
    a_r10_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (!ex_valid && !ex_we && !mem_store_bypass));
endmodule

// File: tb/test_operand_hazard_unit.sv
// Table-driven bench for the operand hazard unit, then directed corner tests.
module test_operand_hazard_unit;
    localparam int AW = 5;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_valid = 1'b0;
    logic [AW-1:0] id_rs = '0, id_rt = '0, id_rd = '0;
    logic          id_we = 1'b0, id_load = 1'b0, id_store = 1'b0;
    logic [1:0]    fwd_rs_sel, fwd_rt_sel;
    logic          raw_rs, raw_rt, hold_front, ex_bubble, ex_valid, ex_we;
    logic [AW-1:0] ex_rd;
    logic          mem_store_bypass;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    operand_hazard_unit i_operand_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs(id_rs),
        .id_rt(id_rt), .id_rd(id_rd), .id_we(id_we), .id_load(id_load),
        .id_store(id_store), .fwd_rs_sel(fwd_rs_sel), .fwd_rt_sel(fwd_rt_sel),
        .raw_rs(raw_rs), .raw_rt(raw_rt), .hold_front(hold_front),
        .ex_bubble(ex_bubble), .ex_valid(ex_valid), .ex_we(ex_we),
        .ex_rd(ex_rd), .mem_store_bypass(mem_store_bypass)
    );

    // Row: valid rs rt rd we ld st | sel_rs sel_rt raw_rs raw_rt hold mbyp ex_valid ex_rd
    localparam logic [32:0] VEC [NV] = '{
        {1'b1,5'd2, 5'd3, 5'd1, 1'b1,1'b0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0 }, // 0 empty pipe
        {1'b1,5'd1, 5'd3, 5'd4, 1'b1,1'b0,1'b0, 2'd1,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,5'd1 }, // 1 R3 producer in execute
        {1'b1,5'd1, 5'd7, 5'd6, 1'b1,1'b0,1'b0, 2'd2,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,5'd4 }, // 2 R3 producer in memory
        {1'b1,5'd1, 5'd9, 5'd31,1'b1,1'b0,1'b0, 2'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,5'd6 }, // 3 R1 writeback flagged, no path
        {1'b1,5'd31,5'd31,5'd31,1'b1,1'b0,1'b0, 2'd1,2'd1,1'b1,1'b1,1'b0,1'b0,1'b1,5'd31}, // 4 both operands
        {1'b1,5'd31,5'd0, 5'd0, 1'b1,1'b0,1'b0, 2'd1,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,5'd31}, // 5 R4 nearest of ex/mem
        {1'b1,5'd0, 5'd0, 5'd9, 1'b1,1'b1,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0 }, // 6 R2 r0 written in ex
        {1'b1,5'd9, 5'd3, 5'd3, 1'b1,1'b0,1'b0, 2'd0,2'd0,1'b1,1'b0,1'b1,1'b0,1'b1,5'd9 }, // 7 R5 load-use hold
        {1'b1,5'd9, 5'd3, 5'd3, 1'b1,1'b0,1'b0, 2'd2,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,5'd3 }, // 8 R8 R6 bubble, mem load
        {1'b1,5'd3, 5'd0, 5'd4, 1'b1,1'b1,1'b0, 2'd1,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,5'd3 }, // 9 load r4
        {1'b1,5'd5, 5'd4, 5'd0, 1'b0,1'b0,1'b1, 2'd0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd4 }, // 10 R7 store data from load
        {1'b1,5'd0, 5'd0, 5'd0, 1'b0,1'b0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0 }, // 11 store in execute
        {1'b0,5'd0, 5'd0, 5'd0, 1'b0,1'b0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,5'd0 }, // 12 R7 store in memory
        {1'b1,5'd0, 5'd0, 5'd7, 1'b1,1'b1,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0 }, // 13 load r7
        {1'b1,5'd7, 5'd7, 5'd0, 1'b0,1'b0,1'b1, 2'd0,2'd0,1'b1,1'b1,1'b1,1'b0,1'b1,5'd7 }, // 14 R5 store address on load
        {1'b1,5'd7, 5'd7, 5'd0, 1'b0,1'b0,1'b1, 2'd2,2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,5'd0 }, // 15 R8 both from memory
        {1'b0,5'd0, 5'd0, 5'd0, 1'b0,1'b0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0 }, // 16 drain
        {1'b0,5'd0, 5'd0, 5'd0, 1'b0,1'b0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0 }  // 17 R7 stalled store no bypass
    };

    task automatic chk(input string req, input string what, input int step,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s step %0d: actual %0d expected %0d", req, what, step, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                         input logic [AW-1:0] rd, input logic we, input logic ld, input logic st);
        id_valid = v; id_rs = rs; id_rt = rt; id_rd = rd;
        id_we = we; id_load = ld; id_store = st;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R10", "ex_valid after reset", -1, ex_valid, 0);
        chk("R10", "ex_rd after reset", -1, ex_rd, 0);
        chk("R10", "mem_store_bypass after reset", -1, mem_store_bypass, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][32], VEC[i][31:27], VEC[i][26:22], VEC[i][21:17],
                  VEC[i][16], VEC[i][15], VEC[i][14]);
            #2;
            chk("R3", "fwd_rs_sel", i, fwd_rs_sel, VEC[i][13:12]);
            chk("R3", "fwd_rt_sel", i, fwd_rt_sel, VEC[i][11:10]);
            chk("R1", "raw_rs", i, raw_rs, VEC[i][9]);
            chk("R1", "raw_rt", i, raw_rt, VEC[i][8]);
            chk("R5", "hold_front", i, hold_front, VEC[i][7]);
            chk("R5", "ex_bubble", i, ex_bubble, VEC[i][7]);
            chk("R7", "mem_store_bypass", i, mem_store_bypass, VEC[i][6]);
            chk("R6", "ex_valid", i, ex_valid, VEC[i][5]);
            chk("R6", "ex_rd", i, ex_rd, VEC[i][4:0]);
        end

        // R6: the bubble of step 7 also carried no write enable
        // (step 8 already saw ex_valid low; check ex_we on a fresh bubble)
        @(negedge clk); drive(1, 0, 0, 12, 1, 1, 0);      // load r12
        @(negedge clk); drive(1, 12, 0, 13, 1, 0, 0);     // use r12 -> hold
        #2; chk("R5", "hold on r12 use", 100, hold_front, 1);
        @(negedge clk); #2;
        chk("R6", "bubble ex_we", 101, ex_we, 0);
        chk("R6", "bubble ex_rd", 101, ex_rd, 13);
        chk("R8", "r12 from memory", 101, fwd_rs_sel, 2);

        // R9: invalid decode reading the register of a load in execute
        @(negedge clk); drive(1, 0, 0, 5, 1, 1, 0);       // load r5
        @(negedge clk); drive(0, 5, 5, 0, 0, 0, 0);
        #2;
        chk("R9", "hold with invalid slot", 102, hold_front, 0);
        chk("R9", "raw_rs with invalid slot", 102, raw_rs, 0);
        chk("R9", "raw_rt with invalid slot", 102, raw_rt, 0);
        chk("R9", "fwd_rs_sel with invalid slot", 102, fwd_rs_sel, 0);

        // R10: reset while a load is in decode flushes every stage
        @(negedge clk); drive(1, 0, 0, 6, 1, 1, 0); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; drive(1, 6, 6, 0, 1, 0, 0);
        #2;
        chk("R10", "ex_valid after mid-run reset", 103, ex_valid, 0);
        chk("R10", "hold after mid-run reset", 103, hold_front, 0);
        chk("R10", "raw_rs after mid-run reset", 103, raw_rs, 0);
        chk("R10", "raw_rt after mid-run reset", 103, raw_rt, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule